// File: doc/BRIEF.md
# Stack and Interrupt Sequencer

This block carries out the control transfers of an 8-bit processor that go through a one-page hardware stack. It runs the reset vector fetch and software break. It also runs subroutine call and return, return from interrupt, and single-byte push and pull of the accumulator and of the status register. It owns the stack pointer, the 16-bit program counter, the accumulator and the status register. All memory traffic goes over a byte-wide port that makes one access per cycle. Read data comes back the cycle after the request.

Operand decoding and arithmetic sit elsewhere. A call arrives with its target already resolved on `target_i`. An operation is started by a one-cycle `start_i` with a 3-bit code on `op_i`. `busy_o` stays high while the sequence runs. `done_o` pulses once the registers hold their new values. After reset the block fetches the reset vector on its own, without a start.

Top module: `stack_seq`

## Requirements
- R1: After `rst_ni` rises, the block reads 0xFFFC and then 0xFFFD without a start. It then sets PC to {byte at 0xFFFD, byte at 0xFFFC} and SP to 0xFD. The accumulator reads 0x00 and the status reads 0x20.
- R2: Every stack access uses address 0x0100 + SP. A push writes at SP and then decrements SP. A pull increments SP and then reads at the new SP. SP wraps modulo 256 in both directions. Every address the block drives is on page 0x01 or is one of 0xFFFC to 0xFFFF.
- R3: Code 1 (call) writes (PC-1) high byte, then low byte, onto the stack, then sets PC to `target_i` as sampled at start.
- R4: Code 2 (return) pulls the low byte, then the high byte, and sets PC to that value plus 1.
- R5: Code 0 (break) pushes (PC+1) high byte, then low byte, then status OR 0x10. It then reads 0xFFFE and 0xFFFF, sets PC to that little-endian value and sets status bit 2.
- R6: Code 3 (return from interrupt) pulls the status byte first and stores it unchanged, bit 5 included. It then pulls the low and high PC bytes and sets PC to that value.
- R7: Code 4 pushes the accumulator. Code 5 pushes the status with bit 4 set in the stored byte. Neither operation changes PC, the accumulator or the status.
- R8: Code 6 loads the accumulator from a pull. It sets status bit 1 when the byte is zero and copies byte bit 7 into status bit 7. All other status bits are left unchanged.
- R9: Code 7 loads the status from a pull with bit 5 forced to 1.
- R10: An operation with n memory accesses raises `done_o` n+1 cycles after the edge that accepts `start_i`. The access counts are 1 for codes 4 to 7, 2 for codes 1 and 2, 3 for code 3 and 5 for code 0. After reset, `done_o` rises at the third edge. `done_o` lasts one cycle, with `busy_o` low. Memory requests occur only while `busy_o` is high.
- R11: `start_i` has no effect while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start an operation (sampled when idle) |
| op_i | input | 3 | Operation code |
| target_i | input | 16 | Call target |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 16 | Access address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the request |
| pc_o | output | 16 | Program counter |
| sp_o | output | 8 | Stack pointer |
| acc_o | output | 8 | Accumulator |
| status_o | output | 8 | Status register |

## Verification
Results fall due at different times:
- Each operation's done pulse and register updates come n+1 cycles after the accepting edge, with n from 1 to 5 by operation.
- Each stack access changes SP at the edge that ends that access.
- The reset fetch completes at the third edge after release.

The bench drives on falling edges and counts rising edges until `done_o` is seen. It compares that count with n+2, which includes the accepting edge, and compares the registers in the same sample. It then confirms `done_o` has dropped one cycle later. Its memory model logs each access in order, so the stack address, the direction and the byte order of every access are checked against the SP that the bench predicts.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  localparam int STEP_W = 3;

  typedef enum logic [3:0] {
    OP_BRK    = 4'd0,
    OP_CALL   = 4'd1,
    OP_RET    = 4'd2,
    OP_RTI    = 4'd3,
    OP_PUSH_A = 4'd4,
    OP_PUSH_S = 4'd5,
    OP_PULL_A = 4'd6,
    OP_PULL_S = 4'd7,
    OP_RESET  = 4'd8
  } op_e;

  typedef enum logic [1:0] {ACC_NONE, ACC_PUSH, ACC_PULL, ACC_VEC} acc_e;
  typedef enum logic [1:0] {WSEL_HI, WSEL_LO, WSEL_STAT, WSEL_ACC} wsel_e;
  typedef enum logic [1:0] {DST_LO, DST_HI, DST_BYTE, DST_NONE} dst_e;

  typedef struct packed {
    acc_e  acc;
    wsel_e wsel;
    dst_e  dst;
    logic  vec_hi;
  } step_t;

  localparam step_t IDLE_STEP = '{acc: ACC_NONE, wsel: WSEL_ACC, dst: DST_NONE, vec_hi: 1'b0};

  function automatic step_t mk_step(acc_e a, wsel_e w, dst_e d, logic h);
    step_t s;
    s.acc = a;
    s.wsel = w;
    s.dst = d;
    s.vec_hi = h;
    return s;
  endfunction

endpackage

// File: rtl/stack_seq_plan.sv
module stack_seq_plan
  import stack_seq_pkg::*;
(
  input  op_e               op_i,
  input  logic [STEP_W-1:0] step_i,
  output step_t             step_o,
  output logic [STEP_W-1:0] count_o
);

  always_comb begin
    step_o  = IDLE_STEP;
    count_o = '0;
    case (op_i)
      OP_RESET: begin
        count_o = 3'd2;
        case (step_i)
          3'd0: step_o = mk_step(ACC_VEC, WSEL_ACC, DST_LO, 1'b0);
          3'd1: step_o = mk_step(ACC_VEC, WSEL_ACC, DST_HI, 1'b1);
          default: step_o = IDLE_STEP;
        endcase
      end
      OP_BRK: begin
        count_o = 3'd5;
        case (step_i)
          3'd0: step_o = mk_step(ACC_PUSH, WSEL_HI,   DST_NONE, 1'b0);
          3'd1: step_o = mk_step(ACC_PUSH, WSEL_LO,   DST_NONE, 1'b0);
          3'd2: step_o = mk_step(ACC_PUSH, WSEL_STAT, DST_NONE, 1'b0);
          3'd3: step_o = mk_step(ACC_VEC,  WSEL_ACC,  DST_LO,   1'b0);
          3'd4: step_o = mk_step(ACC_VEC,  WSEL_ACC,  DST_HI,   1'b1);
          default: step_o = IDLE_STEP;
        endcase
      end
      OP_CALL: begin
        count_o = 3'd2;
        case (step_i)
          3'd0: step_o = mk_step(ACC_PUSH, WSEL_HI, DST_NONE, 1'b0);
          3'd1: step_o = mk_step(ACC_PUSH, WSEL_LO, DST_NONE, 1'b0);
          default: step_o = IDLE_STEP;
        endcase
      end
      OP_RET: begin
        count_o = 3'd2;
        case (step_i)
          3'd0: step_o = mk_step(ACC_PULL, WSEL_ACC, DST_LO, 1'b0);
          3'd1: step_o = mk_step(ACC_PULL, WSEL_ACC, DST_HI, 1'b0);
          default: step_o = IDLE_STEP;
        endcase
      end
      OP_RTI: begin
        count_o = 3'd3;
        case (step_i)
          3'd0: step_o = mk_step(ACC_PULL, WSEL_ACC, DST_BYTE, 1'b0);
          3'd1: step_o = mk_step(ACC_PULL, WSEL_ACC, DST_LO,   1'b0);
          3'd2: step_o = mk_step(ACC_PULL, WSEL_ACC, DST_HI,   1'b0);
          default: step_o = IDLE_STEP;
        endcase
      end
      OP_PUSH_A: begin
        count_o = 3'd1;
        if (step_i == 3'd0) step_o = mk_step(ACC_PUSH, WSEL_ACC, DST_NONE, 1'b0);
      end
      OP_PUSH_S: begin
        count_o = 3'd1;
        if (step_i == 3'd0) step_o = mk_step(ACC_PUSH, WSEL_STAT, DST_NONE, 1'b0);
      end
      OP_PULL_A, OP_PULL_S: begin
        count_o = 3'd1;
        if (step_i == 3'd0) step_o = mk_step(ACC_PULL, WSEL_ACC, DST_BYTE, 1'b0);
      end
      default: begin
        step_o  = IDLE_STEP;
        count_o = '0;
      end
    endcase
  end

endmodule

// File: rtl/stack_seq_ptr.sv
module stack_seq_ptr #(
  parameter logic [7:0] PAGE = 8'h01,
  parameter logic [7:0] INIT = 8'hFD
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        push_i,
  input  logic        pull_i,
  output logic [7:0]  sp_o,
  output logic [15:0] push_addr_o,
  output logic [15:0] pull_addr_o
);

  logic [7:0] sp_q;
  logic [7:0] sp_inc;

  assign sp_inc = sp_q + 8'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sp_q <= INIT;
    else if (init_i)  sp_q <= INIT;
    else if (push_i)  sp_q <= sp_q - 8'd1;
    else if (pull_i)  sp_q <= sp_inc;
  end

  assign sp_o        = sp_q;
  assign push_addr_o = {PAGE, sp_q};
  assign pull_addr_o = {PAGE, sp_inc};

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter logic [15:0] RESET_VEC   = 16'hFFFC,
  parameter logic [15:0] BREAK_VEC   = 16'hFFFE,
  parameter logic [7:0]  STACK_PAGE  = 8'h01,
  parameter logic [7:0]  SP_INIT     = 8'hFD,
  parameter logic [7:0]  STATUS_INIT = 8'h20
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [2:0]  op_i,
  input  logic [15:0] target_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [15:0] mem_addr_o,
  output logic [7:0]  mem_wdata_o,
  input  logic [7:0]  mem_rdata_i,
  output logic [15:0] pc_o,
  output logic [7:0]  sp_o,
  output logic [7:0]  acc_o,
  output logic [7:0]  status_o
);

  localparam logic [7:0] BRK_BIT  = 8'h10;
  localparam logic [7:0] ONE_BIT  = 8'h20;

  logic              busy_q, done_q;
  op_e               op_q;
  logic [STEP_W-1:0] step_q, count;
  dst_e              dst_q;
  logic [7:0]        lo_q, hi_q, byte_q, acc_q, st_q;
  logic [15:0]       pc_q, tgt_q;

  step_t       cur;
  logic        issuing, finish, do_push, do_pull, init_sp;
  logic [15:0] push_addr, pull_addr, ret_addr, vec_base;
  logic [7:0]  lo_n, hi_n, byte_n;

  stack_seq_plan u_plan (
    .op_i    (op_q),
    .step_i  (step_q),
    .step_o  (cur),
    .count_o (count)
  );

  assign issuing = busy_q && (step_q < count);
  assign finish  = busy_q && (step_q == count);
  assign do_push = issuing && (cur.acc == ACC_PUSH);
  assign do_pull = issuing && (cur.acc == ACC_PULL);
  assign init_sp = finish && (op_q == OP_RESET);

  stack_seq_ptr #(
    .PAGE (STACK_PAGE),
    .INIT (SP_INIT)
  ) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_i      (init_sp),
    .push_i      (do_push),
    .pull_i      (do_pull),
    .sp_o        (sp_o),
    .push_addr_o (push_addr),
    .pull_addr_o (pull_addr)
  );

  // break pushes PC+1, call pushes PC-1
  assign ret_addr = (op_q == OP_BRK) ? pc_q + 16'd1 : pc_q - 16'd1;
  assign vec_base = (op_q == OP_RESET) ? RESET_VEC : BREAK_VEC;

  always_comb begin
    mem_req_o   = issuing && (cur.acc != ACC_NONE);
    mem_we_o    = do_push;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (cur.acc)
      ACC_PUSH: mem_addr_o = push_addr;
      ACC_PULL: mem_addr_o = pull_addr;
      ACC_VEC:  mem_addr_o = vec_base + {15'd0, cur.vec_hi};
      default:  mem_addr_o = '0;
    endcase
    case (cur.wsel)
      WSEL_HI:   mem_wdata_o = ret_addr[15:8];
      WSEL_LO:   mem_wdata_o = ret_addr[7:0];
      WSEL_STAT: mem_wdata_o = st_q | BRK_BIT;
      default:   mem_wdata_o = acc_q;
    endcase
  end

  // read data lands one cycle after its request
  assign lo_n   = (dst_q == DST_LO)   ? mem_rdata_i : lo_q;
  assign hi_n   = (dst_q == DST_HI)   ? mem_rdata_i : hi_q;
  assign byte_n = (dst_q == DST_BYTE) ? mem_rdata_i : byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      op_q   <= OP_RESET;
      step_q <= '0;
      dst_q  <= DST_NONE;
      lo_q   <= '0;
      hi_q   <= '0;
      byte_q <= '0;
      acc_q  <= '0;
      st_q   <= STATUS_INIT;
      pc_q   <= '0;
      tgt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      lo_q   <= lo_n;
      hi_q   <= hi_n;
      byte_q <= byte_n;
      dst_q  <= (issuing && (cur.acc == ACC_PULL || cur.acc == ACC_VEC)) ? cur.dst : DST_NONE;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          op_q   <= op_e'({1'b0, op_i});
          step_q <= '0;
          tgt_q  <= target_i;
        end
      end else if (!finish) begin
        step_q <= step_q + 1'b1;
      end else begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        case (op_q)
          OP_RESET: pc_q <= {hi_n, lo_n};
          OP_BRK: begin
            pc_q    <= {hi_n, lo_n};
            st_q[2] <= 1'b1;
          end
          OP_CALL:  pc_q <= tgt_q;
          OP_RET:   pc_q <= {hi_n, lo_n} + 16'd1;
          OP_RTI: begin
            pc_q <= {hi_n, lo_n};
            st_q <= byte_n;
          end
          OP_PULL_A: begin
            acc_q <= byte_n;
            st_q  <= {byte_n[7], st_q[6:2], byte_n == 8'd0, st_q[0]};
          end
          OP_PULL_S: st_q <= byte_n | ONE_BIT;
          default: ;
        endcase
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign pc_o     = pc_q;
  assign acc_o    = acc_q;
  assign status_o = st_q;

endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        done_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [15:0] mem_addr_o,
  input logic [7:0]  sp_o
);

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R10
  req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  // R10
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));

  // R2
  push_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_addr_o == {STACK_PAGE, sp_o}));

  // R2
  push_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |=> (sp_o == $past(sp_o) - 8'd1));

  // R2
  pull_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_addr_o[15:8] == STACK_PAGE)
      |-> (mem_addr_o[7:0] == sp_o + 8'd1));

  // R2
  pull_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_addr_o[15:8] == STACK_PAGE)
      |=> (sp_o == $past(sp_o) + 8'd1));

endmodule

bind stack_seq stack_seq_chk #(.STACK_PAGE(STACK_PAGE)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .sp_o       (sp_o)
);

// File: tb/stack_seq_test.sv
module stack_seq_test;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [15:0] target_i = '0;
  logic        busy_o, done_o, mem_req_o, mem_we_o;
  logic [15:0] mem_addr_o, pc_o;
  logic [7:0]  mem_wdata_o, sp_o, acc_o, status_o;
  logic [7:0]  mem_rdata_i = '0;

  int checks = 0;
  int failures = 0;

  localparam logic [15:0] RV = 16'h3412;
  localparam logic [15:0] BV = 16'hC0DE;

  logic [7:0]  stk [256];
  logic [15:0] log_a [8];
  logic        log_w [8];
  logic [7:0]  log_d [8];
  int          log_n = 0;
  int          bad_acc = 0;

  logic [15:0] m_pc;
  logic [7:0]  m_sp, m_a, m_st;

  always #4 clk_i = ~clk_i;

  stack_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i), .target_i(target_i),
    .busy_o(busy_o), .done_o(done_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .pc_o(pc_o), .sp_o(sp_o), .acc_o(acc_o), .status_o(status_o)
  );

  function automatic logic [7:0] rd_mem(input logic [15:0] a);
    if (a == 16'hFFFC) return RV[7:0];
    if (a == 16'hFFFD) return RV[15:8];
    if (a == 16'hFFFE) return BV[7:0];
    if (a == 16'hFFFF) return BV[15:8];
    if (a[15:8] == 8'h01) return stk[a[7:0]];
    return 8'h00;
  endfunction

  always @(posedge clk_i) begin
    if (mem_req_o && rst_ni) begin
      if (log_n < 8) begin
        log_a[log_n] <= mem_addr_o;
        log_w[log_n] <= mem_we_o;
        log_d[log_n] <= mem_we_o ? mem_wdata_o : rd_mem(mem_addr_o);
        log_n <= log_n + 1;
      end
      if (mem_we_o) begin
        if (mem_addr_o[15:8] == 8'h01) stk[mem_addr_o[7:0]] <= mem_wdata_o;
        else bad_acc <= bad_acc + 1;
      end else begin
        if (mem_addr_o[15:8] != 8'h01 && mem_addr_o[15:2] != 14'h3FFF) bad_acc <= bad_acc + 1;
        mem_rdata_i <= rd_mem(mem_addr_o);
      end
    end
  end

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    check(req, "pc", pc_o, m_pc);
    check(req, "sp", {8'h00, sp_o}, {8'h00, m_sp});
    check(req, "acc", {8'h00, acc_o}, {8'h00, m_a});
    check(req, "status", {8'h00, status_o}, {8'h00, m_st});
  endtask

  // R10: done after n+1 cycles, counted here as n+2 edges including the accepting one
  task automatic run(input logic [2:0] op, input logic [15:0] tgt, input int n);
    int cnt;
    @(negedge clk_i);
    log_n = 0;
    start_i = 1'b1; op_i = op; target_i = tgt;
    @(posedge clk_i); @(negedge clk_i);
    start_i = 1'b0;
    cnt = 1;
    while (!done_o && cnt < 20) begin
      @(posedge clk_i); @(negedge clk_i);
      cnt++;
    end
    check("R10", "latency", 16'(cnt), 16'(n + 2));
    check("R10", "busy_at_done", {15'd0, busy_o}, 16'd0);
    @(posedge clk_i); @(negedge clk_i);
    check("R10", "done_width", {15'd0, done_o}, 16'd0);
  endtask

  task automatic call_t(input logic [15:0] tgt);
    logic [15:0] r;
    r = m_pc - 16'd1;
    run(3'd1, tgt, 2);
    check("R3", "acc_count", 16'(log_n), 16'd2);
    check("R2", "call_addr0", log_a[0], {8'h01, m_sp});
    check("R2", "call_addr1", log_a[1], {8'h01, 8'(m_sp - 8'd1)});
    check("R3", "call_hi", {7'd0, log_w[0], log_d[0]}, {8'h01, r[15:8]});
    check("R3", "call_lo", {7'd0, log_w[1], log_d[1]}, {8'h01, r[7:0]});
    m_sp = m_sp - 8'd2;
    m_pc = tgt;
    check_regs("R3");
  endtask

  task automatic ret_t();
    logic [7:0] lo, hi;
    lo = stk[8'(m_sp + 8'd1)];
    hi = stk[8'(m_sp + 8'd2)];
    run(3'd2, 16'h0000, 2);
    check("R4", "ret_addr0", log_a[0], {8'h01, 8'(m_sp + 8'd1)});
    check("R4", "ret_addr1", log_a[1], {8'h01, 8'(m_sp + 8'd2)});
    check("R4", "ret_reads", {14'd0, log_w[0], log_w[1]}, 16'd0);
    m_sp = m_sp + 8'd2;
    m_pc = {hi, lo} + 16'd1;
    check_regs("R4");
  endtask

  task automatic pull_a_t(input logic [7:0] v);
    stk[8'(m_sp + 8'd1)] = v;
    run(3'd6, 16'h0000, 1);
    check("R2", "pull_a_addr", log_a[0], {8'h01, 8'(m_sp + 8'd1)});
    m_sp = m_sp + 8'd1;
    m_a = v;
    m_st = {v[7], m_st[6:2], v == 8'd0, m_st[0]};
    check_regs("R8");
  endtask

  task automatic push_a_t();
    run(3'd4, 16'h0000, 1);
    check("R7", "push_a_log", {7'd0, log_w[0], log_d[0]}, {8'h01, m_a});
    check("R2", "push_a_addr", log_a[0], {8'h01, m_sp});
    check("R7", "push_a_mem", {8'h00, stk[m_sp]}, {8'h00, m_a});
    m_sp = m_sp - 8'd1;
    check_regs("R7");
  endtask

  task automatic pull_s_t(input logic [7:0] v);
    stk[8'(m_sp + 8'd1)] = v;
    run(3'd7, 16'h0000, 1);
    check("R2", "pull_s_addr", log_a[0], {8'h01, 8'(m_sp + 8'd1)});
    m_sp = m_sp + 8'd1;
    m_st = v | 8'h20;
    check_regs("R9");
  endtask

  task automatic push_s_t();
    run(3'd5, 16'h0000, 1);
    check("R7", "push_s_mem", {8'h00, stk[m_sp]}, {8'h00, m_st | 8'h10});
    check("R2", "push_s_addr", log_a[0], {8'h01, m_sp});
    m_sp = m_sp - 8'd1;
    check_regs("R7");
  endtask

  task automatic brk_t();
    logic [15:0] r;
    r = m_pc + 16'd1;
    run(3'd0, 16'h0000, 5);
    check("R5", "acc_count", 16'(log_n), 16'd5);
    check("R5", "brk_a0", log_a[0], {8'h01, m_sp});
    check("R5", "brk_a1", log_a[1], {8'h01, 8'(m_sp - 8'd1)});
    check("R5", "brk_a2", log_a[2], {8'h01, 8'(m_sp - 8'd2)});
    check("R5", "brk_hi", {8'h00, log_d[0]}, {8'h00, r[15:8]});
    check("R5", "brk_lo", {8'h00, log_d[1]}, {8'h00, r[7:0]});
    check("R5", "brk_st", {8'h00, log_d[2]}, {8'h00, m_st | 8'h10});
    check("R5", "brk_v0", log_a[3], 16'hFFFE);
    check("R5", "brk_v1", log_a[4], 16'hFFFF);
    m_sp = m_sp - 8'd3;
    m_pc = BV;
    m_st = m_st | 8'h04;
    check_regs("R5");
  endtask

  task automatic rti_t();
    logic [7:0] s, lo, hi;
    s  = stk[8'(m_sp + 8'd1)];
    lo = stk[8'(m_sp + 8'd2)];
    hi = stk[8'(m_sp + 8'd3)];
    run(3'd3, 16'h0000, 3);
    check("R6", "rti_a0", log_a[0], {8'h01, 8'(m_sp + 8'd1)});
    check("R6", "rti_a2", log_a[2], {8'h01, 8'(m_sp + 8'd3)});
    m_sp = m_sp + 8'd3;
    m_st = s;
    m_pc = {hi, lo};
    check_regs("R6");
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog R10 actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cnt;
    for (int i = 0; i < 256; i++) stk[i] = 8'h00;
    repeat (3) @(negedge clk_i);
    log_n = 0;
    rst_ni = 1'b1;
    cnt = 0;
    while (!done_o && cnt < 20) begin
      @(posedge clk_i); @(negedge clk_i);
      cnt++;
    end
    check("R10", "reset_latency", 16'(cnt), 16'd3);
    check("R1", "reset_reads", 16'(log_n), 16'd2);
    check("R1", "reset_a0", log_a[0], 16'hFFFC);
    check("R1", "reset_a1", log_a[1], 16'hFFFD);
    m_pc = RV; m_sp = 8'hFD; m_a = 8'h00; m_st = 8'h20;
    check_regs("R1");

    // call / return, nested, including PC wrap through 0x0000
    for (int i = 0; i < 12; i++) begin
      logic [15:0] t;
      t = (i == 0) ? 16'h0000 : (i == 1) ? 16'hFFFF : 16'(i * 16'h1357 + 16'hF00D);
      call_t(t);
      call_t(~t);
      ret_t();
      ret_t();
    end
    call_t(16'h0000);
    call_t(16'h4321);
    ret_t();
    ret_t();

    // accumulator pull/push sweep; net one push per step wraps SP downward
    pull_s_t(8'h41);
    for (int v = 0; v < 256; v++) begin
      pull_a_t(8'(v));
      push_a_t();
      push_a_t();
    end

    // status pull/push sweep; net one pull per step wraps SP upward
    for (int v = 0; v < 256; v++) begin
      pull_s_t(8'(v));
      pull_s_t(8'(v) ^ 8'h5A);
      push_s_t();
    end

    // break and return from interrupt
    for (int k = 0; k < 4; k++) begin
      logic [7:0] sv;
      sv = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h5A : 8'h81;
      pull_s_t(sv);
      call_t(16'(k * 16'h2468 + 16'h0101));
      brk_t();
      rti_t();
    end
    // stored status has bit 5 clear: must come back raw
    stk[8'(m_sp + 8'd1)] = 8'h00;
    stk[8'(m_sp + 8'd2)] = 8'h78;
    stk[8'(m_sp + 8'd3)] = 8'h56;
    rti_t();
    stk[8'(m_sp + 8'd1)] = 8'hC3;
    stk[8'(m_sp + 8'd2)] = 8'hFF;
    stk[8'(m_sp + 8'd3)] = 8'hFF;
    rti_t();

    // R11: start while busy is ignored
    @(negedge clk_i);
    start_i = 1'b1; op_i = 3'd1; target_i = 16'hBEEF;
    @(posedge clk_i); @(negedge clk_i);
    op_i = 3'd6; target_i = 16'h1111;
    @(posedge clk_i); @(negedge clk_i);
    start_i = 1'b0;
    cnt = 0;
    while (!done_o && cnt < 20) begin
      @(posedge clk_i); @(negedge clk_i);
      cnt++;
    end
    m_sp = m_sp - 8'd2;
    m_pc = 16'hBEEF;
    check_regs("R11");
    repeat (3) @(negedge clk_i);
    check("R11", "stays_idle", {15'd0, busy_o}, 16'd0);
    check_regs("R11");

    check("R2", "stray_accesses", 16'(bad_acc), 16'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule